// File: doc/BRIEF.md
# SPI Serial Clock Generator with Two Division Laws

This block derives the serial clock of an SPI master from the faster module clock. A shifter beside it needs to know when the serial clock moves, so the block also emits two strobes. Each strobe is one module-clock cycle wide and is high in the same cycle that the serial clock changes level. One strobe marks edges that leave the idle level (leading). The other marks edges that return to it (trailing). The shifter combines these strobes with its own phase setting to decide when to shift and when to sample.

The divider is set by one 13-bit configuration word, and bit 12 chooses how the word is read. In linear mode each half period lasts N+1 module cycles, so the serial period is 2×(N+1). In power-of-two mode each half period lasts 2^M module cycles, so the serial period is 2^(M+1). The configuration word and the idle polarity are captured while the run input is low. They are then frozen for the whole run, so software may rewrite them at any time without disturbing a run in progress. Working out divider values from a target frequency is left to software.

Top module: `spi_sclk_gen`

## Requirements
- R1: While reset is held, `sclk`, `lead_en` and `trail_en` are all 0.
- R2: On any clock edge where `run` is low, the block does four things: it loads `sclk` with `idle_pol`, drives both strobes to 0, clears its half-period counter, and captures `div_cfg` and `idle_pol`.
- R3: When `div_cfg[12]` is 1 at capture, the half period lasts N+1 module cycles, where N = `div_cfg[7:0]`.
- R4: When `div_cfg[12]` is 0 at capture, the half period lasts 2^M module cycles, where M = `div_cfg[11:8]`.
- R5: Let h be the half period. Counting the clock edges at which `run` is sampled high as 1, 2, 3 and so on, `sclk` toggles at every edge whose number is a multiple of h, and at no other edge.
- R6: An edge that moves `sclk` away from the captured idle level raises `lead_en`. An edge that moves it back to that level raises `trail_en`. Each strobe is high only in the cycle of its edge.
- R7: `lead_en` and `trail_en` are never high together, and neither is high in two consecutive cycles.
- R8: While `run` stays high, changes to `div_cfg` and `idle_pol` have no effect. They take effect only after `run` has been low for at least one edge.
- R9: With linear mode and N=0, `sclk` toggles on every module-clock edge, which gives half the module-clock rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High while the transfer engine wants the serial clock to run |
| idle_pol | input | 1 | Idle level of `sclk` (clock polarity) |
| div_cfg | input | 13 | [7:0] linear count N, [11:8] power exponent M, [12] 1 = linear, 0 = power-of-two |
| sclk | output | 1 | Serial clock |
| lead_en | output | 1 | One-cycle strobe on each edge leaving the idle level |
| trail_en | output | 1 | One-cycle strobe on each edge returning to the idle level |

## Verification
The assertions assume that `idle_pol` and `div_cfg` matter only through the values captured while `run` is low. They also assume that `run` is a plain level with no timing relation to the serial clock. The polarity checks on the strobes compare against the captured idle level and not the live input, so they stay valid when the live inputs move during a run. The stimulus changes configuration only on falling module-clock edges and only while `run` is low. The single exception is one deliberate mid-run rewrite, and the expected waveform for that case is still computed from the captured values.

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4,
  localparam int CFG_W = LIN_W + POW_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             idle_pol,
  input  logic [CFG_W-1:0] div_cfg,
  output logic             sclk,
  output logic             lead_en,
  output logic             trail_en
);
  localparam int POW_MAX = (1 << POW_W) - 1;
  localparam int CNT_W   = ((POW_MAX > LIN_W) ? POW_MAX : LIN_W) + 1;

  logic [CFG_W-1:0] cfg_q;
  logic             pol_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;

  always_comb begin
    if (cfg_q[CFG_W-1])
      half_m1 = CNT_W'(cfg_q[LIN_W-1:0]);
    else
      half_m1 = (CNT_W'(1) << cfg_q[LIN_W +: POW_W]) - CNT_W'(1);
  end

  wire hit = (cnt == half_m1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      pol_q    <= 1'b0;
      cnt      <= '0;
      sclk     <= 1'b0;
      lead_en  <= 1'b0;
      trail_en <= 1'b0;
    end else if (!run) begin
      cfg_q    <= div_cfg;
      pol_q    <= idle_pol;
      cnt      <= '0;
      sclk     <= idle_pol;
      lead_en  <= 1'b0;
      trail_en <= 1'b0;
    end else if (hit) begin
      cnt      <= '0;
      sclk     <= ~sclk;
      lead_en  <= (sclk == pol_q);
      trail_en <= (sclk != pol_q);
    end else begin
      cnt      <= cnt + CNT_W'(1);
      lead_en  <= 1'b0;
      trail_en <= 1'b0;
    end
  end

  // R2
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(idle_pol)) && !lead_en && !trail_en);

  // R6
  lead_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_en |-> (sclk != pol_q) && ($past(sclk) == pol_q));

  // R6
  trail_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_en |-> (sclk == pol_q) && ($past(sclk) != pol_q));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lead_en && trail_en));

  // R7
  lead_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lead_en |=> !lead_en);

  // R7
  trail_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trail_en |=> !trail_en);

  // R5
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && $past(rst_n)) |-> ((lead_en || trail_en) == (sclk != $past(sclk))));

  // R8
  frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && $past(rst_n)) |-> ($stable(cfg_q) && $stable(pol_q)));
endmodule

// File: tb/spi_sclk_gen_tb.sv
`timescale 1ns/1ps
module spi_sclk_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        idle_pol = 1'b0;
  logic [12:0] div_cfg = '0;
  logic        sclk, lead_en, trail_en;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  spi_sclk_gen dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .idle_pol(idle_pol),
    .div_cfg(div_cfg), .sclk(sclk), .lead_en(lead_en), .trail_en(trail_en)
  );

  task automatic check3(string req, logic s, logic l, logic t, logic es, logic el, logic et);
    total++;
    if (s !== es || l !== el || t !== et) begin
      bad++;
      $display("FAIL %s: sclk/lead/trail actual=%b%b%b expected=%b%b%b",
               req, s, l, t, es, el, et);
    end
  endtask

  task automatic run_case(bit lin, int val, bit pol, bit mid_change, string req);
    int h;
    int len;
    h = lin ? (val + 1) : (1 << val);
    len = 4 * h + 3;
    @(negedge clk);
    div_cfg  = lin ? {1'b1, 4'd0, 8'(val)} : {1'b0, 4'(val), 8'd0};
    idle_pol = pol;
    @(negedge clk);
    check3("R2", sclk, lead_en, trail_en, pol, 1'b0, 1'b0);
    run = 1'b1;
    for (int t = 1; t <= len; t++) begin
      int tg;
      bit edge_now;
      @(negedge clk);
      if (mid_change && t == 2) begin
        div_cfg  = ~div_cfg;
        idle_pol = ~pol;
      end
      tg = t / h;
      edge_now = (t % h) == 0;
      check3(mid_change ? "R8" : req, sclk, lead_en, trail_en,
             pol ^ tg[0], edge_now && tg[0], edge_now && !tg[0]);
    end
    idle_pol = pol;
    run = 1'b0;
    @(negedge clk);
    check3("R2", sclk, lead_en, trail_en, pol, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    div_cfg = 13'h1FFF;
    run = 1'b1;
    idle_pol = 1'b1;
    repeat (3) @(negedge clk);
    check3("R1", sclk, lead_en, trail_en, 1'b0, 1'b0, 1'b0);
    run = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    run_case(1'b1, 0, 1'b0, 1'b0, "R9");
    run_case(1'b1, 0, 1'b1, 1'b0, "R9");
    for (int n = 1; n < 16; n++)
      for (int p = 0; p < 2; p++)
        run_case(1'b1, n, p[0], 1'b0, "R3");
    run_case(1'b1, 255, 1'b0, 1'b0, "R3");
    for (int m = 0; m < 10; m++)
      for (int p = 0; p < 2; p++)
        run_case(1'b0, m, p[0], 1'b0, "R4");
    run_case(1'b1, 5, 1'b0, 1'b0, "R5");
    run_case(1'b0, 2, 1'b1, 1'b0, "R6");
    run_case(1'b1, 3, 1'b0, 1'b1, "R8");
    run_case(1'b0, 3, 1'b1, 1'b1, "R8");
    run_case(1'b1, 1, 1'b0, 1'b0, "R7");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule